// File: doc/BRIEF.md
# Serial EEPROM command sequencer

This block runs single read, write and erase commands on a three-wire serial configuration EEPROM. A requester presents an operation code, a 6-bit word address and, for writes, a 16-bit data word on a valid/ready request port. The sequencer builds the whole command frame and drives it one bit at a time on the serial data line. It frames the transfer with chip select and toggles the shift clock with a counted wait between every edge. On reads it gathers the 16 bits the device returns.

Each frame holds 27 bit times. A leading idle zero comes first, then a start bit that is always one, the 2-bit opcode, the address and a turnaround zero. The 16 data bits close the frame. Data out changes only while the shift clock is low. Data from the device is sampled as the clock rises. When chip select drops, a one-cycle completion pulse fires. After a read the captured word sits on the result output until the next read completes.

Top module: `ee_cmd_seq`

## Requirements
- R1: While reset is asserted and just after it, chip select, shift clock, serial data out and the done pulse are low, req_ready is high and rdata_o is zero.
- R2: Serial data out, sampled at each of the 27 rising shift-clock edges, forms this frame. Bit 0 is zero. Bit 1 is one. Bits 2-3 are the opcode: 10 read, 01 write, 11 erase. Bits 4-9 are the address, most significant bit first. Bit 10 is zero. Bits 11-26 are the write data, most significant bit first, and are zero for read and erase.
- R3: Exactly 27 rising shift-clock edges happen while chip select is high, for every operation.
- R4: The shift clock stays high for DELAY clock cycles and low for DELAY cycles between rising edges. It is never high while chip select is low. Serial data out does not change while the shift clock is high.
- R5: Chip select rises on the clock edge that accepts a request. The first rising shift-clock edge follows DELAY cycles later. Chip select falls DELAY cycles after the last falling shift-clock edge, so it stays high for 55×DELAY cycles.
- R6: For a read, the device bits sampled at the rising edges of frame bits 11-26 are placed in rdata_o, the first one at bit 15. rdata_o is valid when done_o pulses.
- R7: done_o is a single-cycle pulse. It is high on the cycle in which chip select has just fallen.
- R8: rdata_o changes only on the completion of a read. Write and erase operations leave it unchanged.
- R9: While an operation is in progress, req_ready is low and requests are ignored. A request withdrawn before the operation ends is never carried out.
- R10: A request held valid across the completion is accepted on the next clock edge, so chip select is low for exactly one cycle between two operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Opcode: 10 read, 01 write, 11 erase |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Data to write (write only) |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| do_i | input | 1 | Serial data from the EEPROM |
| cs_o | output | 1 | Chip select to the EEPROM |
| sk_o | output | 1 | Shift clock to the EEPROM |
| di_o | output | 1 | Serial data to the EEPROM |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last word read |

## Verification
The assertions check the serial line discipline on every cycle. They confirm that the clock stays inside chip select, that data is stable while the clock is high and that the clock high time is exact. They also count 27 rising edges per frame and check the single done pulse that lines up with chip select falling, the held result word and the busy/ready relation. The actual bit contents of each frame, the address decode and the data the device returns can only be judged against the bench's responder and memory model. The same holds for the phase lengths measured from acceptance, the rejection of a request made while busy and the one-cycle gap between back-to-back commands.

// File: rtl/ee_seq_pkg.sv
package ee_seq_pkg;

   // opcode bits that follow the start bit
   typedef enum logic [1:0] {
      EE_OP_WRITE = 2'b01,
      EE_OP_READ  = 2'b10,
      EE_OP_ERASE = 2'b11
   } ee_op_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_LOW,
      SEQ_HIGH,
      SEQ_TAIL
   } seq_state_e;

   localparam int unsigned EE_OP_W   = 2;
   localparam int unsigned EE_START_W = 1;

endpackage

// File: rtl/ee_frame_build.sv
module ee_frame_build
   import ee_seq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned LEAD_W  = 1,
   parameter int unsigned TURN_W  = 1,
   parameter int unsigned FRAME_W = LEAD_W + EE_START_W + EE_OP_W + ADDR_W + TURN_W + DATA_W
) (
   input  logic [EE_OP_W-1:0] op,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [FRAME_W-1:0] frame
);

   localparam int unsigned CMD_W    = EE_START_W + EE_OP_W + ADDR_W;
   localparam int unsigned CMD_SHIFT = TURN_W + DATA_W;
   localparam int unsigned SUM_W    = LEAD_W + CMD_W + CMD_SHIFT;

   generate
      if (SUM_W != FRAME_W) begin : g_bad_frame_w
         $error("ee_frame_build: FRAME_W does not match the field widths");
      end
   endgenerate

   logic [CMD_W-1:0]   cmd_bits;
   logic [FRAME_W-1:0] cmd_field;
   logic [FRAME_W-1:0] data_field;

   always_comb begin
      cmd_bits   = {1'b1, op, addr};
      cmd_field  = FRAME_W'(cmd_bits) << CMD_SHIFT;
      data_field = (op == EE_OP_WRITE) ? FRAME_W'(wdata) : '0;
      frame      = cmd_field | data_field;
   end

endmodule

// File: rtl/ee_edge_timer.sv
module ee_edge_timer #(
   parameter int unsigned DELAY = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expire
);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("ee_edge_timer: DELAY must be at least 1");
      end
      if (DELAY == 1) begin : g_direct
         assign expire = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DELAY);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load) begin
               cnt <= CW'(DELAY - 1);
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign expire = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/ee_rx_capture.sv
module ee_rx_capture #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] word
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("ee_rx_capture: DATA_W must be at least 1");
      end
      if (DATA_W == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)        word <= '0;
            else if (shift_en) word <= bit_in;
         end
      end else begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n)        word <= '0;
            else if (shift_en) word <= {word[DATA_W-2:0], bit_in};
         end
      end
   endgenerate

endmodule

// File: rtl/ee_cmd_seq.sv
module ee_cmd_seq
   import ee_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LEAD_W = 1,
   parameter int unsigned TURN_W = 1,
   parameter int unsigned DELAY  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  logic              do_i,
   output logic              cs_o,
   output logic              sk_o,
   output logic              di_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int unsigned FRAME_W = LEAD_W + EE_START_W + EE_OP_W + ADDR_W + TURN_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W);

   generate
      if (ADDR_W < 1 || DATA_W < 1 || DELAY < 1) begin : g_bad_param
         $error("ee_cmd_seq: ADDR_W, DATA_W and DELAY must be at least 1");
      end
   endgenerate

   seq_state_e         state;
   logic [FRAME_W-1:0] frame_next;
   logic [FRAME_W-1:0] tx_sr;
   logic [CNT_W-1:0]   bit_cnt;
   logic [1:0]         op_q;
   logic               expire;
   logic               tmr_load;
   logic               accept;
   logic               rx_shift;
   logic [DATA_W-1:0]  rx_word;

   ee_frame_build #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LEAD_W (LEAD_W),
      .TURN_W (TURN_W),
      .FRAME_W(FRAME_W)
   ) u_frame (
      .op   (req_op),
      .addr (req_addr),
      .wdata(req_wdata),
      .frame(frame_next)
   );

   ee_edge_timer #(
      .DELAY(DELAY)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .expire(expire)
   );

   ee_rx_capture #(
      .DATA_W(DATA_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(rx_shift),
      .bit_in  (do_i),
      .word    (rx_word)
   );

   assign req_ready = (state == SEQ_IDLE);
   assign accept    = req_ready && req_valid;
   assign tmr_load  = accept || ((state != SEQ_IDLE) && expire);
   // sample on the rising edge of the last DATA_W bit slots
   assign rx_shift  = (state == SEQ_LOW) && expire && (bit_cnt < CNT_W'(DATA_W));
   assign di_o      = tx_sr[FRAME_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         tx_sr   <= '0;
         bit_cnt <= '0;
         op_q    <= '0;
         cs_o    <= 1'b0;
         sk_o    <= 1'b0;
         done_o  <= 1'b0;
         rdata_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (req_valid) begin
                  state   <= SEQ_LOW;
                  cs_o    <= 1'b1;
                  tx_sr   <= frame_next;
                  bit_cnt <= CNT_W'(FRAME_W - 1);
                  op_q    <= req_op;
               end
            end
            SEQ_LOW: begin
               if (expire) begin
                  sk_o  <= 1'b1;
                  state <= SEQ_HIGH;
               end
            end
            SEQ_HIGH: begin
               if (expire) begin
                  sk_o <= 1'b0;
                  if (bit_cnt == '0) begin
                     state <= SEQ_TAIL;
                     tx_sr <= '0;
                  end else begin
                     tx_sr   <= tx_sr << 1;
                     bit_cnt <= bit_cnt - 1'b1;
                     state   <= SEQ_LOW;
                  end
               end
            end
            SEQ_TAIL: begin
               if (expire) begin
                  cs_o   <= 1'b0;
                  done_o <= 1'b1;
                  state  <= SEQ_IDLE;
                  if (op_q == EE_OP_READ) begin
                     rdata_o <= rx_word;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ee_cmd_seq_chk.sv
module ee_cmd_seq_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DELAY   = 40,
   parameter int unsigned FRAME_W = 27
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              cs_o,
   input logic              sk_o,
   input logic              di_o,
   input logic              done_o,
   input logic [DATA_W-1:0] rdata_o
);

   localparam int unsigned HW = $clog2(DELAY + 2);
   localparam int unsigned RW = $clog2(FRAME_W + 2);

   logic [HW-1:0] hi_cnt;
   logic [RW-1:0] rise_cnt;
   logic          sk_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         rise_cnt <= '0;
         sk_prev  <= 1'b0;
      end else begin
         sk_prev <= sk_o;
         hi_cnt  <= sk_o ? hi_cnt + 1'b1 : '0;
         if (!cs_o)                  rise_cnt <= '0;
         else if (sk_o && !sk_prev)  rise_cnt <= rise_cnt + 1'b1;
      end
   end

   // R4: shift clock only inside chip select
   a_r4_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_o |-> !sk_o);

   // R4: data out holds while the clock is high
   a_r4_di_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      sk_o |-> $stable(di_o));

   // R4: clock high phase lasts DELAY cycles
   a_r4_sk_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      (!sk_o && $past(sk_o)) |-> (hi_cnt == HW'(DELAY)));

   // R3: rising edges per frame
   a_r3_rise_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_o && $past(cs_o)) |-> (rise_cnt == RW'(FRAME_W)));

   // R7: done is a single pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: done coincides with chip select falling
   a_r7_done_with_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!cs_o && $past(cs_o)));

   // R8: result only moves on completion
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(rdata_o));

   // R9: no acceptance while busy
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cs_o |-> !req_ready);

endmodule

bind ee_cmd_seq ee_cmd_seq_chk #(
   .DATA_W (DATA_W),
   .DELAY  (DELAY),
   .FRAME_W(FRAME_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .cs_o     (cs_o),
   .sk_o     (sk_o),
   .di_o     (di_o),
   .done_o   (done_o),
   .rdata_o  (rdata_o)
);

// File: tb/ee_cmd_seq_test.sv
`timescale 1ns/1ps
module ee_cmd_seq_test;

   localparam int DLY = 5;
   localparam int NV  = 9;
   localparam logic [1:0] OP_WR = 2'b01, OP_RD = 2'b10, OP_ER = 2'b11;

   // {op, addr, wdata, expected read word}
   localparam logic [39:0] VEC [NV] = '{
      {OP_WR, 6'h05, 16'hA5C3, 16'h0000},
      {OP_WR, 6'h3F, 16'h1234, 16'h0000},
      {OP_RD, 6'h05, 16'h0000, 16'hA5C3},
      {OP_RD, 6'h3F, 16'h0000, 16'h1234},
      {OP_ER, 6'h05, 16'h0000, 16'h0000},
      {OP_RD, 6'h05, 16'h0000, 16'hFFFF},
      {OP_WR, 6'h00, 16'h8001, 16'h0000},
      {OP_RD, 6'h00, 16'h0000, 16'h8001},
      {OP_RD, 6'h2A, 16'h0000, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [5:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        do_i = 1'b0;
   logic        cs_o, sk_o, di_o, done_o;
   logic [15:0] rdata_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   // responder state
   logic [15:0] mem [64];
   logic [26:0] rx_frame = '0;
   int          rise_n = 0;
   logic [1:0]  dev_op = '0;
   logic [15:0] dev_word = '0;

   ee_cmd_seq #(.DELAY(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .do_i(do_i), .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o),
      .done_o(done_o), .rdata_o(rdata_o)
   );

   always #2 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // simple serial EEPROM model
   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
   end
   initial forever begin
      @(posedge cs_o);
      rise_n = 0; rx_frame = '0; do_i = 1'b0;
   end
   initial forever begin
      @(posedge sk_o);
      rx_frame = {rx_frame[25:0], di_o};
      rise_n = rise_n + 1;
   end
   initial forever begin
      @(negedge sk_o);
      if (rise_n == 10) begin
         dev_op = rx_frame[7:6];
         dev_word = mem[rx_frame[5:0]];
      end
      if (dev_op == OP_RD && rise_n >= 11 && rise_n <= 26) do_i = dev_word[26 - rise_n];
      else do_i = 1'b0;
   end
   initial forever begin
      @(negedge cs_o);
      if (rx_frame[24:23] == OP_WR) mem[rx_frame[22:17]] = rx_frame[15:0];
      else if (rx_frame[24:23] == OP_ER) mem[rx_frame[22:17]] = 16'hFFFF;
   end

   task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(cs_o == 1'b1, "R5 cs high after accept", cs_o, 1);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_o && n < 2000) begin @(negedge clk); n++; end
      check(done_o == 1'b1 && cs_o == 1'b0, "R7 done with cs low", {done_o, cs_o}, 2'b10);
   endtask

   function automatic logic [26:0] exp_frame(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
      return {1'b0, 1'b1, op, a, 1'b0, (op == OP_WR) ? d : 16'h0000};
   endfunction

   // watchdog
   initial forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] last_rd;
      int n;
      // R1 reset state
      repeat (3) @(negedge clk);
      check({cs_o, sk_o, di_o, done_o, req_ready} == 5'b00001, "R1 outputs in reset",
            {cs_o, sk_o, di_o, done_o, req_ready}, 5'b00001);
      rst_n = 1'b1;
      @(negedge clk);
      check({cs_o, sk_o, di_o, done_o, req_ready} == 5'b00001 && rdata_o == 16'h0,
            "R1 outputs after reset", {cs_o, sk_o, di_o, done_o, req_ready, rdata_o}, 21'h1_0000);
      last_rd = 16'h0000;

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [1:0] op; logic [5:0] a; logic [15:0] d, e;
         {op, a, d, e} = VEC[v];
         issue(op, a, d);
         wait_done();
         check(rx_frame == exp_frame(op, a, d), "R2 frame contents", rx_frame, exp_frame(op, a, d));
         check(rise_n == 27, "R3 rising edge count", rise_n, 27);
         if (op == OP_RD) begin
            check(rdata_o == e, "R6 read word", rdata_o, e);
            last_rd = e;
         end else begin
            check(rdata_o == last_rd, "R8 rdata kept", rdata_o, last_rd);
         end
         @(negedge clk);
         check(done_o == 1'b0, "R7 single pulse", done_o, 0);
      end

      // R4/R5 phase lengths
      @(negedge clk);
      req_op = OP_RD; req_addr = 6'h3F; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!sk_o) begin @(negedge clk); n++; end
      check(n == DLY + 1, "R5 cs to first clock rise", n, DLY + 1);
      n = 0;
      while (sk_o) begin @(negedge clk); n++; end
      check(n == DLY, "R4 clock high width", n, DLY);
      n = 0;
      while (!sk_o) begin @(negedge clk); n++; end
      check(n == DLY, "R4 clock low width", n, DLY);
      n = 2 * DLY + 1 + DLY;
      while (cs_o) begin @(negedge clk); n++; end
      check(n == 55 * DLY + 1, "R5 chip select duration", n, 55 * DLY + 1);
      check(rdata_o == 16'h1234, "R6 read after timing run", rdata_o, 16'h1234);

      // R9 request during busy is ignored
      issue(OP_RD, 6'h00, 16'h0000);
      repeat (30) @(negedge clk);
      req_op = OP_WR; req_addr = 6'h2A; req_wdata = 16'hBEEF; req_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(req_ready == 1'b0, "R9 not ready while busy", req_ready, 0);
      end
      req_valid = 1'b0;
      wait_done();
      check(rx_frame == exp_frame(OP_RD, 6'h00, 16'h0), "R9 frame unchanged", rx_frame, exp_frame(OP_RD, 6'h00, 16'h0));
      n = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (cs_o) n++; end
      check(n == 0, "R9 no later operation", n, 0);
      issue(OP_RD, 6'h2A, 16'h0000);
      wait_done();
      check(rdata_o == 16'h0000, "R9 ignored write left word", rdata_o, 16'h0000);

      // R10 back-to-back
      @(negedge clk);
      req_op = OP_RD; req_addr = 6'h05; req_valid = 1'b1;
      while (!done_o) @(negedge clk);
      req_addr = 6'h00;
      check(rdata_o == 16'hFFFF, "R6 first of pair", rdata_o, 16'hFFFF);
      @(negedge clk);
      check(cs_o == 1'b1, "R10 accepted after one low cycle", cs_o, 1);
      req_valid = 1'b0;
      wait_done();
      check(rdata_o == 16'h8001, "R10 second of pair", rdata_o, 16'h8001);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule